// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Priority Selector

This block sits between the interrupt state storage of a multi-processor interrupt controller and each processor's request input. Every clock it looks at a bank of interrupt sources separately for each CPU interface. A source is a candidate for that CPU when it is both enabled and pending in that CPU's view. Among the candidates the block picks the one with the most urgent priority. A smaller 8-bit value means higher urgency. It then registers the result: the identifier of the selected source and a request line for that CPU.

The result passes through two gates. The winner appears on the identifier output only if its priority is strictly below the CPU's priority mask. The request line rises only if the winner also beats the priority the CPU is already running. An empty or blocked selection reports the reserved identifier 1023. Turning off the global distribution enable forces every CPU to that idle state. Turning off one CPU's interface enable does the same for that CPU only.

The number of sources and the number of CPUs are parameters. A third parameter chooses whether the scan runs as one linear chain or as two half-bank chains that are merged at the end.

Top module: `irq_prio_sel`

## Requirements
- R1: While reset is asserted, every CPU's identifier output reads 1023 and every request line is low, whatever the inputs.
- R2: When a CPU has no source that is both enabled and pending, its identifier output reads 1023 and its request line is low.
- R3: When the global distribution enable is low, every CPU's request line is low and every identifier output reads 1023.
- R4: When one CPU's interface enable is low, that CPU's request line is low and its identifier reads 1023. The other CPUs are not affected.
- R5: Only sources that are enabled and pending for a CPU compete. The candidate with the numerically smallest priority wins.
- R6: Among candidates of equal priority, the one with the lowest identifier wins. This holds across the whole bank, including the boundary between the two scan halves.
- R7: The winner is reported only when its priority is strictly less than the CPU's 8-bit priority mask. Otherwise the identifier reads 1023 and the request line is low.
- R8: A reported winner raises the request line only when its priority is strictly less than the CPU's 9-bit running priority, where 256 means nothing is running. An equal or larger running value leaves the identifier reported with the request line low.
- R9: Outputs are registered. A change on any input appears at the outputs after the next rising clock edge and not before it.
- R10: Each CPU's selection uses only that CPU's slice of the enable, pending, priority, mask and running-priority inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global distribution enable |
| cpu_en | input | N_CPU | Per-CPU interface enable, bit c for CPU c |
| src_en | input | N_CPU*N_SRC | Enable of source i as seen by CPU c, at bit c*N_SRC+i |
| src_pend | input | N_CPU*N_SRC | Pending state of source i for CPU c, at bit c*N_SRC+i |
| src_prio | input | N_CPU*N_SRC*8 | Priority of source i for CPU c, at bits (c*N_SRC+i)*8 +: 8 |
| prio_mask | input | N_CPU*8 | Priority mask of CPU c, at bits c*8 +: 8 |
| run_prio | input | N_CPU*9 | Running priority of CPU c, at bits c*9 +: 9, with 256 meaning idle |
| hp_id | output | N_CPU*10 | Highest pending identifier of CPU c, at bits c*10 +: 10, with 1023 meaning none |
| irq_req | output | N_CPU | Request line of CPU c |

## Verification
Both outputs come from one register stage, so each result is due one rising edge after the inputs that produce it. The driver changes inputs just after a falling edge and pushes the expected identifiers and request lines, which it works out from the requirements, into a queue. The monitor pops each entry a quarter period after the following rising edge and compares it. Shortly after each input change, and before that edge, the driver also checks that the outputs still hold the previous expectation. This confirms that no result shows up early.

// File: rtl/ips_pkg.sv
package ips_pkg;
   localparam int PRIO_W  = 8;
   localparam int RUN_W   = PRIO_W + 1;
   localparam int ID_W    = 10;
   localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;

   typedef logic [PRIO_W-1:0] prio_t;

   typedef struct packed {
      logic             hit;
      logic [ID_W-1:0]  id;
      prio_t            prio;
   } pick_t;

   localparam pick_t NO_PICK = '{hit: 1'b0, id: IDLE_ID, prio: '1};

   // lo covers lower identifiers; it keeps ties
   function automatic pick_t pick_merge(input pick_t lo, input pick_t hi);
      if (lo.hit && (!hi.hit || lo.prio <= hi.prio))
         return lo;
      return hi;
   endfunction
endpackage

// File: rtl/ips_scan.sv
module ips_scan
   import ips_pkg::*;
#(
   parameter int N    = 8,
   parameter int BASE = 0
) (
   input  logic [N-1:0]        cand,
   input  logic [N*PRIO_W-1:0] prio,
   output pick_t               best
);
   always_comb begin
      best = NO_PICK;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (!best.hit || prio[i*PRIO_W +: PRIO_W] < best.prio)) begin
            best.hit  = 1'b1;
            best.id   = ID_W'(BASE + i);
            best.prio = prio[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/ips_bank.sv
module ips_bank
   import ips_pkg::*;
#(
   parameter int N_SRC      = 16,
   parameter bit SPLIT_SCAN = 1'b1
) (
   input  logic [N_SRC-1:0]        cand,
   input  logic [N_SRC*PRIO_W-1:0] prio,
   output pick_t                   best
);
   localparam int LO_N = N_SRC / 2;
   localparam int HI_N = N_SRC - LO_N;

   if (SPLIT_SCAN && N_SRC >= 2) begin : g_split
      pick_t lo_pick, hi_pick;
      ips_scan #(.N(LO_N), .BASE(0)) i_lo (
         .cand (cand[LO_N-1:0]),
         .prio (prio[LO_N*PRIO_W-1:0]),
         .best (lo_pick)
      );
      ips_scan #(.N(HI_N), .BASE(LO_N)) i_hi (
         .cand (cand[N_SRC-1:LO_N]),
         .prio (prio[N_SRC*PRIO_W-1:LO_N*PRIO_W]),
         .best (hi_pick)
      );
      assign best = pick_merge(lo_pick, hi_pick);
   end else begin : g_linear
      ips_scan #(.N(N_SRC), .BASE(0)) i_all (
         .cand (cand),
         .prio (prio),
         .best (best)
      );
   end
endmodule

// File: rtl/ips_gate.sv
module ips_gate
   import ips_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_on,
   input  pick_t            pick,
   input  prio_t            mask,
   input  logic [RUN_W-1:0] run_prio,
   output logic [ID_W-1:0]  id_q,
   output logic             irq_q
);
   logic pass_mask;
   logic pass_run;

   assign pass_mask = gate_on && pick.hit && (pick.prio < mask);
   assign pass_run  = {1'b0, pick.prio} < run_prio;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q  <= IDLE_ID;
         irq_q <= 1'b0;
      end else if (pass_mask) begin
         id_q  <= pick.id;
         irq_q <= pass_run;
      end else begin
         id_q  <= IDLE_ID;
         irq_q <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import ips_pkg::*;
#(
   parameter int N_SRC      = 16,
   parameter int N_CPU      = 2,
   parameter bit SPLIT_SCAN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dist_en,
   input  logic [N_CPU-1:0]              cpu_en,
   input  logic [N_CPU*N_SRC-1:0]        src_en,
   input  logic [N_CPU*N_SRC-1:0]        src_pend,
   input  logic [N_CPU*N_SRC*PRIO_W-1:0] src_prio,
   input  logic [N_CPU*PRIO_W-1:0]       prio_mask,
   input  logic [N_CPU*RUN_W-1:0]        run_prio,
   output logic [N_CPU*ID_W-1:0]         hp_id,
   output logic [N_CPU-1:0]              irq_req
);
   localparam int BANK_W = N_SRC * PRIO_W;

   if (N_SRC < 1 || N_SRC > 1020) begin : g_bad_src
      $error("irq_prio_sel: N_SRC must lie in 1..1020");
   end
   if (N_CPU < 1 || N_CPU > 8) begin : g_bad_cpu
      $error("irq_prio_sel: N_CPU must lie in 1..8");
   end

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      logic [N_SRC-1:0] cand;
      pick_t            best;

      assign cand = src_en[c*N_SRC +: N_SRC] & src_pend[c*N_SRC +: N_SRC];

      ips_bank #(.N_SRC(N_SRC), .SPLIT_SCAN(SPLIT_SCAN)) i_bank (
         .cand (cand),
         .prio (src_prio[c*BANK_W +: BANK_W]),
         .best (best)
      );

      ips_gate i_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .gate_on  (dist_en & cpu_en[c]),
         .pick     (best),
         .mask     (prio_mask[c*PRIO_W +: PRIO_W]),
         .run_prio (run_prio[c*RUN_W +: RUN_W]),
         .id_q     (hp_id[c*ID_W +: ID_W]),
         .irq_q    (irq_req[c])
      );
   end
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk
   import ips_pkg::*;
#(
   parameter int N_SRC = 16,
   parameter int N_CPU = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          dist_en,
   input logic [N_CPU-1:0]              cpu_en,
   input logic [N_CPU*N_SRC-1:0]        src_en,
   input logic [N_CPU*N_SRC-1:0]        src_pend,
   input logic [N_CPU*N_SRC*PRIO_W-1:0] src_prio,
   input logic [N_CPU*PRIO_W-1:0]       prio_mask,
   input logic [N_CPU*RUN_W-1:0]        run_prio,
   input logic [N_CPU*ID_W-1:0]         hp_id,
   input logic [N_CPU-1:0]              irq_req
);
   logic [N_CPU*N_SRC-1:0]        cand_q;
   logic [N_CPU*N_SRC*PRIO_W-1:0] prio_q;
   logic [N_CPU*PRIO_W-1:0]       mask_q;
   logic [N_CPU*RUN_W-1:0]        run_q;

   always_ff @(posedge clk) begin
      cand_q <= src_en & src_pend;
      prio_q <= src_prio;
      mask_q <= prio_mask;
      run_q  <= run_prio;
   end

   // R3
   dist_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dist_en |=> (irq_req == '0));

   for (genvar c = 0; c < N_CPU; c++) begin : g_c
      logic [ID_W-1:0] id_c;
      logic            sel_cand;
      prio_t           sel_prio;

      assign id_c = hp_id[c*ID_W +: ID_W];

      always_comb begin
         sel_cand = 1'b0;
         sel_prio = '1;
         for (int i = 0; i < N_SRC; i++) begin
            if (id_c == ID_W'(i)) begin
               sel_cand = cand_q[c*N_SRC + i];
               sel_prio = prio_q[(c*N_SRC + i)*PRIO_W +: PRIO_W];
            end
         end
      end

      // R4
      cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !cpu_en[c] |=> (!irq_req[c] && hp_id[c*ID_W +: ID_W] == IDLE_ID));
      // R2 R5
      pick_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (id_c != IDLE_ID) |-> sel_cand);
      // R7
      under_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (id_c != IDLE_ID) |-> (sel_prio < mask_q[c*PRIO_W +: PRIO_W]));
      // R8
      irq_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req[c] |-> (id_c != IDLE_ID));
      // R8
      irq_beats_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req[c] |-> ({1'b0, sel_prio} < run_q[c*RUN_W +: RUN_W]));
   end
endmodule

bind irq_prio_sel irq_prio_sel_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU)) i_chk (.*);

// File: tb/test_irq_prio_sel.sv
module test_irq_prio_sel;
   localparam int NS = 16;
   localparam int NC = 2;
   localparam logic [9:0] IDLE = 10'd1023;

   typedef struct {
      logic [NC*10-1:0] ids;
      logic [NC-1:0]    irqs;
      string            tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dist_en;
   logic [NC-1:0] cpu_en;
   logic [NC*NS-1:0] src_en, src_pend;
   logic [NC*NS*8-1:0] src_prio;
   logic [NC*8-1:0] prio_mask;
   logic [NC*9-1:0] run_prio;
   logic [NC*10-1:0] hp_id;
   logic [NC-1:0] irq_req;

   logic       en   [NC][NS];
   logic       pend [NC][NS];
   logic [7:0] pr   [NC][NS];
   logic [7:0] msk  [NC];
   logic [8:0] rp   [NC];

   exp_t q[$];
   exp_t prev;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   always_comb begin
      for (int c = 0; c < NC; c++) begin
         prio_mask[c*8 +: 8] = msk[c];
         run_prio[c*9 +: 9]  = rp[c];
         for (int i = 0; i < NS; i++) begin
            src_en[c*NS+i]            = en[c][i];
            src_pend[c*NS+i]          = pend[c][i];
            src_prio[(c*NS+i)*8 +: 8] = pr[c][i];
         end
      end
   end

   irq_prio_sel #(.N_SRC(NS), .N_CPU(NC)) i_irq_prio_sel (.*);

   task automatic compare(input exp_t e, input string what);
      for (int c = 0; c < NC; c++) begin
         n_run++;
         if (hp_id[c*10 +: 10] !== e.ids[c*10 +: 10] || irq_req[c] !== e.irqs[c]) begin
            n_fail++;
            $display("FAIL %s %s cpu%0d: id=%0d irq=%b expected id=%0d irq=%b", e.tag, what,
                     c, hp_id[c*10 +: 10], irq_req[c], e.ids[c*10 +: 10], e.irqs[c]);
         end
      end
   endtask

   function automatic exp_t model(input string tag);
      exp_t e;
      e.tag = tag;
      for (int c = 0; c < NC; c++) begin
         logic hit = 0;
         logic [7:0] bp = 8'hff;
         logic [9:0] bi = IDLE;
         for (int i = 0; i < NS; i++)
            if (en[c][i] && pend[c][i] && (!hit || pr[c][i] < bp)) begin
               hit = 1; bp = pr[c][i]; bi = 10'(i);
            end
         if (dist_en && cpu_en[c] && hit && bp < msk[c]) begin
            e.ids[c*10 +: 10] = bi;
            e.irqs[c] = ({1'b0, bp} < rp[c]);
         end else begin
            e.ids[c*10 +: 10] = IDLE;
            e.irqs[c] = 1'b0;
         end
      end
      return e;
   endfunction

   // driver: called just after a falling edge with new inputs in place
   task automatic step(input string tag);
      exp_t e = model(tag);
      #2;
      compare(prev, {"R9 hold before edge (", tag, ")"});
      q.push_back(e);
      prev = e;
      @(posedge clk);
      @(negedge clk);
   endtask

   // monitor
   initial forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) compare(q.pop_front(), "after edge");
   end

   task automatic clear_all();
      dist_en = 1; cpu_en = '1;
      for (int c = 0; c < NC; c++) begin
         msk[c] = 8'hff; rp[c] = 9'h100;
         for (int i = 0; i < NS; i++) begin
            en[c][i] = 0; pend[c][i] = 0; pr[c][i] = 8'h80;
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired: run=hung expected=complete");
      finish_run();
   end

   initial begin
      clear_all();
      prev.tag = "R1";
      for (int c = 0; c < NC; c++) begin prev.ids[c*10 +: 10] = IDLE; prev.irqs[c] = 0; end
      // R1: busy inputs during reset
      en[0][2] = 1; pend[0][2] = 1; pr[0][2] = 8'h10;
      en[1][4] = 1; pend[1][4] = 1; pr[1][4] = 8'h10;
      repeat (3) @(negedge clk);
      compare(prev, "R1 reset state");
      clear_all();
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      step("R2 nothing pending");
      en[0][5] = 1; pend[0][5] = 1; pr[0][5] = 8'h40;
      step("R5 R10 single source cpu0");
      en[1][9] = 1; step("R5 enabled not pending");
      pend[1][9] = 0; en[1][9] = 0; pend[1][11] = 1; pr[1][11] = 8'h00;
      step("R5 pending not enabled");
      en[0][1] = 1; pend[0][1] = 1; pr[0][1] = 8'h60;
      en[0][14] = 1; pend[0][14] = 1; pr[0][14] = 8'h30;
      step("R5 smallest value wins");
      pr[0][1] = 8'h30; step("R6 tie lowest id");
      clear_all();
      en[0][7] = 1; pend[0][7] = 1; pr[0][7] = 8'h22;
      en[0][8] = 1; pend[0][8] = 1; pr[0][8] = 8'h22;
      en[1][8] = 1; pend[1][8] = 1; pr[1][8] = 8'h22;
      en[1][15] = 1; pend[1][15] = 1; pr[1][15] = 8'h22;
      step("R6 tie across halves");
      msk[0] = 8'h22; step("R7 mask equal blocks");
      msk[0] = 8'h23; step("R7 mask above passes");
      rp[1] = 9'h022; step("R8 running equal no request");
      rp[1] = 9'h010; step("R8 running lower no request");
      rp[1] = 9'h023; step("R8 running above requests");
      dist_en = 0; step("R3 distribution off");
      dist_en = 1; cpu_en[1] = 0; step("R4 cpu1 interface off");
      cpu_en[1] = 1; cpu_en[0] = 0; step("R4 cpu0 interface off");
      cpu_en = '1; pend[0][7] = 0; pend[0][8] = 0; step("R2 pending cleared");

      for (int k = 0; k < 40; k++) begin
         dist_en = ($urandom % 8) != 0;
         for (int c = 0; c < NC; c++) begin
            cpu_en[c] = ($urandom % 6) != 0;
            msk[c] = 8'($urandom);
            rp[c] = 9'($urandom % 300);
            for (int i = 0; i < NS; i++) begin
               en[c][i]   = ($urandom % 3) == 0;
               pend[c][i] = ($urandom % 3) == 0;
               pr[c][i]   = 8'(($urandom % 4) * 8'h30);
            end
         end
         step("R5 R6 R7 R8 R10 mixed");
      end
      clear_all();
      step("R2 final idle");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule